// File: doc/BRIEF.md
# Keyed Chained Byte-Stream Transformer

This block takes a stream of bytes, one per clock when the input-valid strobe is high, and produces one transformed byte per accepted input. A 24-bit key stays constant for the whole run. The key splits into three byte slices: the high slice, the middle slice and the low slice. For every accepted byte, an unsigned test decides whether the byte is greater than or equal to the high slice. That test picks between two mixing rules. The rules depend on where the byte sits in the stream.

The first byte of a stream is mixed only with a key slice. From the second byte on, the output is built from an intermediate value: the previous input byte XOR the middle slice. That value is then combined with one of three things: the low key slice, the previous output, or the output two positions back. The current byte then only chooses the branch. A start-of-stream strobe begins a new stream. The result is registered, so each output byte appears one cycle after its input, and output-valid follows input-valid with the same delay.

Top module: `bytechain_xform`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the output byte is 0x00 and output-valid is low. Reset also makes the next accepted byte the first byte of a stream and clears all history to zero.
- R2: Output-valid equals input-valid delayed by one clock. An accepted byte's result appears on the output byte in the cycle after the byte is accepted.
- R3: A cycle with input-valid low changes nothing: the output byte holds its value, the stream position does not advance, and the stored previous input and past outputs are kept.
- R4: First byte of a stream: if the byte is greater than or equal to key bits 23:16 (unsigned, equality counts), the output is byte XOR key[23:16]; otherwise the output is byte XOR key[15:8].
- R5: Second byte: let T = previous input byte XOR key[15:8]. If the test holds, the output is T XOR the previous output; otherwise it is T XOR key[7:0].
- R6: Third byte: with T as in R5, if the test holds the output is T XOR the previous output; otherwise it is T XOR the first output of the stream.
- R7: Fourth byte and every later byte: with T as in R5, if the test holds the output is T XOR the previous output; otherwise it is T XOR the output two accepted bytes earlier.
- R8: When the start-of-stream strobe is high on a valid cycle, that byte is treated as a first byte. When the strobe is high on an idle cycle, the next accepted byte is treated as a first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sos_i | input | 1 | Start-of-stream strobe |
| in_vld_i | input | 1 | Input byte valid |
| in_byte_i | input | DATA_W (8) | Input data byte |
| key_i | input | 3*DATA_W (24) | Key, constant during a run |
| out_byte_o | output | DATA_W (8) | Transformed byte, registered |
| out_vld_o | output | 1 | Output byte valid |

## Verification
The hardest situation to reach is the steady-state rule when the input is below the threshold. This case reads an output produced two accepted bytes earlier. Idle gaps, restarts and the threshold comparison all interact there. The stimulus drives long streams with random idle cycles between accepted bytes. It places bytes equal to, just above and just below the high key slice, and raises the start strobe both on idle cycles and on valid cycles in mid-stream. Extra runs use keys whose high slice is 0x00 or 0xFF, which forces one branch almost exclusively.

// File: rtl/bytechain_pkg.sv
package bytechain_pkg;

    // Position of the current byte inside its stream
    typedef enum logic [1:0] {
        POS_FIRST  = 2'd0,
        POS_SECOND = 2'd1,
        POS_THIRD  = 2'd2,
        POS_STEADY = 2'd3
    } pos_e;

    // Saturating step of the stream position
    function automatic pos_e pos_step(input pos_e p);
        case (p)
            POS_FIRST:  return POS_SECOND;
            POS_SECOND: return POS_THIRD;
            default:    return POS_STEADY;
        endcase
    endfunction

endpackage

// File: rtl/bytechain_pos.sv
module bytechain_pos
    import bytechain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sos_i,
    input  logic vld_i,
    output pos_e pos_o
);

    typedef struct packed {
        pos_e pos;
    } pos_state_t;

    pos_state_t state_d, state_q;
    pos_e       eff_pos;

    always_comb begin
        // a start strobe overrides the stored position for this cycle
        eff_pos = sos_i ? POS_FIRST : state_q.pos;
        state_d = state_q;
        if (vld_i) begin
            state_d.pos = pos_step(eff_pos);
        end else if (sos_i) begin
            state_d.pos = POS_FIRST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pos <= POS_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    assign pos_o = eff_pos;

endmodule

// File: rtl/bytechain_mix.sv
module bytechain_mix
    import bytechain_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  pos_e                  pos_i,
    input  logic [DATA_W-1:0]     byte_i,
    input  logic [3*DATA_W-1:0]   key_i,
    input  logic [DATA_W-1:0]     prev_in_i,
    input  logic [DATA_W-1:0]     last_out_i,
    input  logic [DATA_W-1:0]     older_out_i,
    output logic [DATA_W-1:0]     mix_o
);

    localparam int HI_LSB  = 2 * DATA_W;
    localparam int MID_LSB = DATA_W;

    logic [DATA_W-1:0] k_hi, k_mid, k_lo;
    logic [DATA_W-1:0] chain_t;
    logic              at_or_above;

    assign k_hi  = key_i[HI_LSB +: DATA_W];
    assign k_mid = key_i[MID_LSB +: DATA_W];
    assign k_lo  = key_i[0 +: DATA_W];

    always_comb begin
        at_or_above = (byte_i >= k_hi);
        chain_t     = prev_in_i ^ k_mid;
        case (pos_i)
            POS_FIRST:  mix_o = byte_i  ^ (at_or_above ? k_hi       : k_mid);
            POS_SECOND: mix_o = chain_t ^ (at_or_above ? last_out_i : k_lo);
            default:    mix_o = chain_t ^ (at_or_above ? last_out_i : older_out_i);
        endcase
    end

endmodule

// File: rtl/bytechain_hist.sv
module bytechain_hist #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [DATA_W-1:0] mix_i,
    output logic [DATA_W-1:0] prev_in_o,
    output logic [DATA_W-1:0] last_out_o,
    output logic [DATA_W-1:0] older_out_o,
    output logic              vld_o
);

    typedef struct packed {
        logic [DATA_W-1:0] prev_in;
        logic [DATA_W-1:0] last_out;
        logic [DATA_W-1:0] older_out;
        logic              vld;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d     = hist_q;
        hist_d.vld = vld_i;
        if (vld_i) begin
            hist_d.prev_in   = byte_i;
            hist_d.older_out = hist_q.last_out;
            hist_d.last_out  = mix_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign prev_in_o   = hist_q.prev_in;
    assign last_out_o  = hist_q.last_out;
    assign older_out_o = hist_q.older_out;
    assign vld_o       = hist_q.vld;

endmodule

// File: rtl/bytechain_xform.sv
module bytechain_xform
    import bytechain_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sos_i,
    input  logic                in_vld_i,
    input  logic [DATA_W-1:0]   in_byte_i,
    input  logic [3*DATA_W-1:0] key_i,
    output logic [DATA_W-1:0]   out_byte_o,
    output logic                out_vld_o
);

    pos_e              cur_pos;
    logic [DATA_W-1:0] mix_byte;
    logic [DATA_W-1:0] prev_in;
    logic [DATA_W-1:0] last_out;
    logic [DATA_W-1:0] older_out;

    bytechain_pos u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .sos_i (sos_i),
        .vld_i (in_vld_i),
        .pos_o (cur_pos)
    );

    bytechain_mix #(.DATA_W(DATA_W)) u_mix (
        .pos_i       (cur_pos),
        .byte_i      (in_byte_i),
        .key_i       (key_i),
        .prev_in_i   (prev_in),
        .last_out_i  (last_out),
        .older_out_i (older_out),
        .mix_o       (mix_byte)
    );

    bytechain_hist #(.DATA_W(DATA_W)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_i       (in_vld_i),
        .byte_i      (in_byte_i),
        .mix_i       (mix_byte),
        .prev_in_o   (prev_in),
        .last_out_o  (last_out),
        .older_out_o (older_out),
        .vld_o       (out_vld_o)
    );

    // the newest result doubles as the registered output
    assign out_byte_o = last_out;

endmodule

// File: rtl/bytechain_chk.sv
module bytechain_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sos_i,
    input logic                in_vld_i,
    input logic [DATA_W-1:0]   in_byte_i,
    input logic [3*DATA_W-1:0] key_i,
    input logic [DATA_W-1:0]   out_byte_o,
    input logic                out_vld_o
);

    localparam int HI_LSB  = 2 * DATA_W;
    localparam int MID_LSB = DATA_W;

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |=> out_vld_o); // R2

    AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> !out_vld_o); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> $stable(out_byte_o)); // R3

    AST_FIRST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && sos_i && (in_byte_i >= key_i[HI_LSB +: DATA_W]))
        |=> out_byte_o == ($past(in_byte_i) ^ $past(key_i[HI_LSB +: DATA_W]))); // R4

    AST_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && sos_i && (in_byte_i < key_i[HI_LSB +: DATA_W]))
        |=> out_byte_o == ($past(in_byte_i) ^ $past(key_i[MID_LSB +: DATA_W]))); // R8

endmodule

bind bytechain_xform bytechain_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_bytechain_xform.sv
`timescale 1ns/1ps
module test_bytechain_xform;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sos = 1'b0;
    logic        vld = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [23:0] key = 24'h9C5A33;
    logic [7:0]  dout;
    logic        dvld;

    int vectors = 0;
    int fails   = 0;

    // reference model state
    logic [7:0] exp_byte = 8'h00;
    logic       exp_vld  = 1'b0;
    logic [7:0] m_prev_in = 8'h00;
    logic [7:0] m_outs[$];
    int         m_count = 0;
    string      m_tag = "R1";

    always #2.5 clk = ~clk;

    bytechain_xform i_bytechain_xform (
        .clk        (clk),
        .rst_n      (rst_n),
        .sos_i      (sos),
        .in_vld_i   (vld),
        .in_byte_i  (din),
        .key_i      (key),
        .out_byte_o (dout),
        .out_vld_o  (dvld)
    );

    task automatic compare();
        vectors++;
        if (dvld !== exp_vld) begin
            fails++;
            $display("FAIL R2 out_vld actual=%0b expected=%0b", dvld, exp_vld);
        end else if (dout !== exp_byte) begin
            fails++;
            $display("FAIL %s out_byte actual=%02h expected=%02h", m_tag, dout, exp_byte);
        end
    endtask

    task automatic model(input bit s, input bit v, input logic [7:0] b);
        logic [7:0] k2, k1, k0, t, r;
        bit ge;
        k2 = key[23:16]; k1 = key[15:8]; k0 = key[7:0];
        exp_vld = v;
        if (s) begin
            m_count = 0;
            m_outs.delete();
        end
        if (v) begin
            ge = (b >= k2);
            t  = m_prev_in ^ k1;
            if (m_count == 0) begin
                r = ge ? (b ^ k2) : (b ^ k1); m_tag = "R4";
            end else if (m_count == 1) begin
                r = ge ? (t ^ m_outs[m_outs.size()-1]) : (t ^ k0); m_tag = "R5";
            end else if (m_count == 2) begin
                r = t ^ (ge ? m_outs[m_outs.size()-1] : m_outs[0]); m_tag = "R6";
            end else begin
                r = t ^ (ge ? m_outs[m_outs.size()-1] : m_outs[m_outs.size()-2]); m_tag = "R7";
            end
            if (s) m_tag = {m_tag, " R8"};
            m_outs.push_back(r);
            if (m_outs.size() > 2) void'(m_outs.pop_front());
            m_count++;
            m_prev_in = b;
            exp_byte  = r;
        end else begin
            m_tag = s ? "R3 R8" : "R3";
        end
    endtask

    task automatic step(input bit s, input bit v, input logic [7:0] b);
        @(negedge clk);
        compare();
        sos = s; vld = v; din = b;
        model(s, v, b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        compare();
        rst_n = 1'b0; sos = 1'b0; vld = 1'b0; din = 8'h00;
        exp_byte = 8'h00; exp_vld = 1'b0; m_prev_in = 8'h00;
        m_outs.delete(); m_count = 0; m_tag = "R1";
        repeat (2) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = $urandom_range(0, 255);
            if ($urandom_range(0, 3) == 0) b = key[23:16] + 8'($urandom_range(0, 2)) - 8'd1;
            step($urandom_range(0, 29) == 0, $urandom_range(0, 3) != 0, b);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
        step(0, 0, 8'h00);
        // R4..R7: stream right after reset, no start strobe; threshold corners
        step(0, 1, 8'h9C); step(0, 1, 8'h10); step(0, 1, 8'hF0); step(0, 1, 8'h01);
        step(0, 1, 8'h9B); step(0, 1, 8'h9D); step(0, 1, 8'hFF); step(0, 1, 8'h00);
        // R3: idle cycles with junk data
        step(0, 0, 8'hAA); step(0, 0, 8'h55); step(0, 1, 8'h9C); step(0, 0, 8'h12);
        step(0, 1, 8'h20); step(0, 0, 8'hFF); step(0, 1, 8'h30);
        // R8: strobe on an idle cycle, then a new stream
        step(1, 0, 8'h77); step(0, 0, 8'h00);
        step(0, 1, 8'h05); step(0, 1, 8'hC0); step(0, 1, 8'h06); step(0, 1, 8'h07);
        // R8: strobe on a valid cycle in mid-stream
        step(1, 1, 8'hA0); step(0, 1, 8'h11); step(1, 1, 8'h22); step(0, 1, 8'h9C);
        step(0, 1, 8'h33); step(0, 1, 8'h44);
        random_run(600);
        // R1: reset in mid-stream, new keys forcing one branch
        do_reset();
        key = 24'h00FF81;
        random_run(200);
        do_reset();
        key = 24'hFF0F3C;
        random_run(200);
        step(0, 0, 8'h00);
        step(0, 0, 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule